// File: doc/BRIEF.md
# Serial-Link SPI Write Forwarder

This block carries a three-wire SPI write stream across a one-bit serial link. It lives on both ends of the link. On the sending side, the SPI clock comes in on control input bit 5 and the data bit on control input bit 4. When SPI forwarding is enabled and the strobe-select input is 0, every rising SPI clock edge captures the control inputs. The block then sends one short control-only frame. In that frame, the chip-select level takes the bit position that the SPI clock used. No data-bus bits are sent.

On the receiving side, each frame is unpacked onto registered control outputs. One SPI clock pulse is rebuilt per frame. That pulse and the data bit are driven both on the control outputs and on data-bus bits 6 and 7, for displays whose data pins are shared with the SPI pins. Both halves sit in one top module. The transmit link pins and the receive link pins are separate, so two copies can face each other, or one copy can be looped back to itself.

An SPI clock edge that arrives while a frame is still being shifted out is dropped, and a sticky overrun flag is set. All inputs on the sending side are asynchronous. They pass through a parameterised synchroniser before edge detection.

Top module: `spi_link_bridge`

## Requirements
- R1: A frame is sent only while `spi_mode_n` is low. With it high, SPI clock edges produce no frame.
- R2: A frame is sent only while `sel_in` is 0. With `sel_in` at 1, SPI clock edges produce no frame.
- R3: Each rising edge of `ctrl_in[5]` produces exactly one frame. Falling edges produce none.
- R4: A frame holds `link_tx_vld` high for exactly 8 consecutive cycles and sends its bits MSB first on `link_tx_bit`. The bit order, from bit 7 down, is: sel, rw, chip-select, `ctrl_in[4]`, then `ctrl_in[3:0]`. `link_tx_bit` is 0 whenever `link_tx_vld` is low.
- R5: The chip-select level from `cs_in` is carried in frame bit 5. On receipt it appears on `rx_cs`.
- R6: After a frame is received, `rx_ctrl[3:0]`, `rx_rw`, `rx_sel` and `rx_cs` equal the captured values. `rx_ctrl[4]` and `rx_data[7]` both equal the captured SPI data bit.
- R7: Each received frame raises `rx_ctrl[5]` and `rx_data[6]` together for exactly `SCLK_HI` cycles (default 2). All other `rx_data` bits stay 0.
- R8: A rising SPI clock edge that arrives while `link_tx_vld` is high is dropped and sets `ovr_flag`. The flag stays set until reset.
- R9: Reset clears all receive outputs and `ovr_flag`, and leaves the link idle.
- R10: The receive outputs hold their values between frames. Gated or dropped edges leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_mode_n | input | 1 | Low enables SPI forwarding |
| ctrl_in | input | 6 | Control inputs; bit 5 is the SPI clock, bit 4 is the SPI data |
| rw_in | input | 1 | Read/write flag |
| sel_in | input | 1 | Strobe select; must be 0 for forwarding |
| cs_in | input | 1 | SPI chip-select level |
| link_tx_bit | output | 1 | Serial frame bit out |
| link_tx_vld | output | 1 | High while a frame bit is on `link_tx_bit` |
| link_rx_bit | input | 1 | Serial frame bit in |
| link_rx_vld | input | 1 | High while `link_rx_bit` carries a frame bit |
| rx_ctrl | output | 6 | Received control; bit 5 is the rebuilt SPI clock, bit 4 is the SPI data |
| rx_rw | output | 1 | Received read/write flag |
| rx_sel | output | 1 | Received strobe select |
| rx_cs | output | 1 | Received chip-select level |
| rx_data | output | DATA_W | Data bus; bit 7 mirrors SPI data, bit 6 mirrors the rebuilt SPI clock |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or shift register shows up within one frame time, which is about a dozen cycles. It appears either as a frame whose valid window is not 8 cycles long, or as receive outputs whose fields have moved to the wrong places. A broken edge detector or a broken gate shows up as a rebuilt clock pulse count that differs from the number of accepted SPI edges, seen on the next pulse. A lost overrun flag or one that clears itself shows up at once on `ovr_flag`, and the dropped edge shows up as one missing pulse.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  localparam int FRAME_W = 8;

  typedef struct packed {
    logic       sel;
    logic       rw;
    logic       cs;
    logic       sdat;
    logic [3:0] lo;
  } spi_frame_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_tx_packer.sv
module spi_tx_packer
  import spi_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_mode_n,
  input  logic [5:0] ctrl_in,
  input  logic       rw_in,
  input  logic       sel_in,
  input  logic       cs_in,
  output logic       link_bit,
  output logic       link_vld,
  output logic       ovr_flag
);
  localparam int BW = 10;
  localparam int CW = $clog2(FRAME_W);

  logic [BW-1:0] raw, syn;
  logic          s_mode_n, s_cs, s_sel, s_rw;
  logic [5:0]    s_ctrl;
  logic          sclk_d, rise, accept;
  spi_frame_t    frame;
  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0] cnt;

  assign raw = {spi_mode_n, cs_in, sel_in, rw_in, ctrl_in};

  spi_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign {s_mode_n, s_cs, s_sel, s_rw, s_ctrl} = syn;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= s_ctrl[5];
  end

  assign rise   = s_ctrl[5] & ~sclk_d;
  assign accept = rise & ~s_mode_n & ~s_sel;

  always_comb begin
    frame.sel  = s_sel;
    frame.rw   = s_rw;
    frame.cs   = s_cs;
    frame.sdat = s_ctrl[4];
    frame.lo   = s_ctrl[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_vld <= 1'b0;
      link_bit <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (accept && link_vld) ovr_flag <= 1'b1;
      if (link_vld) begin
        if (cnt == '0) begin
          link_vld <= 1'b0;
          link_bit <= 1'b0;
        end else begin
          link_bit <= shreg[FRAME_W-1];
          shreg    <= shreg << 1;
          cnt      <= cnt - 1'b1;
        end
      end else if (accept) begin
        link_vld <= 1'b1;
        link_bit <= frame[FRAME_W-1];
        shreg    <= frame << 1;
        cnt      <= CW'(FRAME_W-1);
      end
    end
  end

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ovr_flag) |-> ovr_flag);
  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !link_vld |-> !link_bit);
  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_vld) |-> $past(!s_mode_n && !s_sel));
endmodule

// File: rtl/spi_rx_unpacker.sv
module spi_rx_unpacker
  import spi_link_pkg::*;
#(
  parameter int SCLK_HI = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_bit,
  input  logic       link_vld,
  output logic [5:0] rx_ctrl,
  output logic       rx_rw,
  output logic       rx_sel,
  output logic       rx_cs,
  output logic       d7_q,
  output logic       d6_q
);
  localparam int CW = $clog2(FRAME_W);
  localparam int PW = $clog2(SCLK_HI + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0]      cnt;
  logic [PW-1:0]      pcnt;
  logic               done;
  spi_frame_t         f;

  assign done = link_vld && (cnt == CW'(FRAME_W-1));
  assign f    = spi_frame_t'({shreg[FRAME_W-2:0], link_bit});

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      cnt     <= '0;
      pcnt    <= '0;
      rx_ctrl <= '0;
      rx_rw   <= 1'b0;
      rx_sel  <= 1'b0;
      rx_cs   <= 1'b0;
      d7_q    <= 1'b0;
      d6_q    <= 1'b0;
    end else begin
      if (link_vld) begin
        shreg <= {shreg[FRAME_W-2:0], link_bit};
        cnt   <= done ? '0 : cnt + 1'b1;
      end
      if (done) begin
        rx_ctrl[3:0] <= f.lo;
        rx_ctrl[4]   <= f.sdat;
        rx_ctrl[5]   <= 1'b1;
        rx_rw        <= f.rw;
        rx_sel       <= f.sel;
        rx_cs        <= f.cs;
        d7_q         <= f.sdat;
        d6_q         <= 1'b1;
        pcnt         <= PW'(SCLK_HI);
      end else if (pcnt > PW'(1)) begin
        pcnt <= pcnt - 1'b1;
      end else if (pcnt == PW'(1)) begin
        pcnt       <= '0;
        rx_ctrl[5] <= 1'b0;
        d6_q       <= 1'b0;
      end
    end
  end

  // R7
  sclk_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    d6_q == rx_ctrl[5]);
  // R6
  sdat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    d7_q == rx_ctrl[4]);
  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ctrl[5]) |-> $past(link_vld && cnt == CW'(FRAME_W-1)));
endmodule

// File: rtl/spi_link_bridge.sv
module spi_link_bridge #(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter int SCLK_HI     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_mode_n,
  input  logic [5:0]        ctrl_in,
  input  logic              rw_in,
  input  logic              sel_in,
  input  logic              cs_in,
  output logic              link_tx_bit,
  output logic              link_tx_vld,
  input  logic              link_rx_bit,
  input  logic              link_rx_vld,
  output logic [5:0]        rx_ctrl,
  output logic              rx_rw,
  output logic              rx_sel,
  output logic              rx_cs,
  output logic [DATA_W-1:0] rx_data,
  output logic              ovr_flag
);
  logic d7, d6;

  spi_tx_packer #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst(rst), .spi_mode_n(spi_mode_n), .ctrl_in(ctrl_in),
    .rw_in(rw_in), .sel_in(sel_in), .cs_in(cs_in),
    .link_bit(link_tx_bit), .link_vld(link_tx_vld), .ovr_flag(ovr_flag)
  );

  spi_rx_unpacker #(.SCLK_HI(SCLK_HI)) u_rx (
    .clk(clk), .rst(rst), .link_bit(link_rx_bit), .link_vld(link_rx_vld),
    .rx_ctrl(rx_ctrl), .rx_rw(rx_rw), .rx_sel(rx_sel), .rx_cs(rx_cs),
    .d7_q(d7), .d6_q(d6)
  );

  always_comb begin
    rx_data    = '0;
    rx_data[7] = d7;
    rx_data[6] = d6;
  end
endmodule

// File: tb/spi_link_bridge_tb.sv
module spi_link_bridge_tb;
  localparam int DW = 18;

  logic clk = 0, rst = 1;
  logic spi_mode_n = 1, rw_in = 0, sel_in = 0, cs_in = 0;
  logic [5:0] ctrl_in = '0;
  logic tx_bit, tx_vld;
  logic [5:0] rx_ctrl;
  logic rx_rw, rx_sel, rx_cs, ovr_flag;
  logic [DW-1:0] rx_data;

  always #2 clk = ~clk;

  spi_link_bridge #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .spi_mode_n(spi_mode_n), .ctrl_in(ctrl_in),
    .rw_in(rw_in), .sel_in(sel_in), .cs_in(cs_in),
    .link_tx_bit(tx_bit), .link_tx_vld(tx_vld),
    .link_rx_bit(tx_bit), .link_rx_vld(tx_vld),
    .rx_ctrl(rx_ctrl), .rx_rw(rx_rw), .rx_sel(rx_sel), .rx_cs(rx_cs),
    .rx_data(rx_data), .ovr_flag(ovr_flag)
  );

  int checks = 0, errors = 0;
  int pulses = 0, pw_bad = 0, mirror_bad = 0, idle_bad = 0, run = 0;
  int vrun = 0, last_len = 0;
  logic [7:0] vshift = '0, last_frame = '0;
  logic prev_sclk = 0, prev_vld = 0;

  always @(negedge clk) begin
    if (rst) begin
      run = 0; vrun = 0; prev_sclk = 0; prev_vld = 0;
    end else begin
      if (rx_ctrl[5] && !prev_sclk) pulses++;
      if (rx_ctrl[5]) run++;
      else if (prev_sclk) begin
        if (run != 2) pw_bad++;
        run = 0;
      end
      if (rx_data[6] != rx_ctrl[5] || rx_data[7] != rx_ctrl[4]) mirror_bad++;
      if ((rx_data & ~(DW'(8'hC0))) != '0) mirror_bad++;
      if (!tx_vld && tx_bit) idle_bad++;
      if (tx_vld) begin vshift = {vshift[6:0], tx_bit}; vrun++; end
      else if (prev_vld) begin last_len = vrun; last_frame = vshift; vrun = 0; end
      prev_sclk = rx_ctrl[5];
      prev_vld  = tx_vld;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(input int hi);
    ctrl_in[5] = 1; cyc(hi); ctrl_in[5] = 0;
  endtask

  function automatic int rx_bundle();
    return {rx_sel, rx_rw, rx_cs, rx_ctrl[4], rx_ctrl[3:0], rx_data[7]};
  endfunction

  // {expect, mode_n, sel, cs, rw, sdat, lo[3:0]}
  localparam logic [9:0] VEC [8] = '{
    10'b1_0_0_0_0_1_1010,
    10'b1_0_0_1_1_0_0101,
    10'b0_1_0_1_1_1_1100,
    10'b0_0_1_0_1_1_0110,
    10'b1_0_0_1_0_1_1111,
    10'b1_0_0_0_1_0_0000,
    10'b0_1_1_0_0_1_1001,
    10'b1_0_0_1_1_1_0011
  };

  bit done = 0;

  initial begin
    cyc(4); rst = 0; cyc(2);
    // R9 reset state
    chk("R9 rx outputs", {rx_ctrl, rx_rw, rx_sel, rx_cs}, 0);
    chk("R9 rx_data", int'(rx_data), 0);
    chk("R9 link idle", {tx_vld, tx_bit}, 0);
    chk("R9 ovr", ovr_flag, 0);

    for (int i = 0; i < 8; i++) begin
      logic [9:0] v;
      int p0, b0;
      v = VEC[i];
      spi_mode_n = v[8]; sel_in = v[7]; cs_in = v[6]; rw_in = v[5];
      ctrl_in[4] = v[4]; ctrl_in[3:0] = v[3:0];
      cyc(4);
      p0 = pulses; b0 = rx_bundle();
      sclk_pulse(3);
      cyc(20);
      // R1 R2 R3: one frame per accepted rising edge, none when gated
      chk("R3/R1/R2 frame count", pulses - p0, int'(v[9]));
      if (v[9]) begin
        // R6 R5
        chk("R6 fields", rx_bundle(),
            {1'b0, v[5], v[6], v[4], v[3:0], v[4]});
        chk("R5 cs", rx_cs, v[6]);
        // R4 serial frame
        chk("R4 frame bits", last_frame, {1'b0, v[5], v[6], v[4], v[3:0]});
        chk("R4 frame length", last_len, 8);
      end else begin
        // R10 outputs hold when gated
        chk("R10 hold", rx_bundle(), b0);
      end
    end

    // R8 overrun
    begin
      int p0, b0;
      spi_mode_n = 0; sel_in = 0; cs_in = 1; rw_in = 0;
      ctrl_in[4] = 0; ctrl_in[3:0] = 4'h6;
      cyc(4);
      p0 = pulses;
      sclk_pulse(2); cyc(2); sclk_pulse(2);
      cyc(25);
      chk("R8 dropped edge", pulses - p0, 1);
      chk("R8 flag set", ovr_flag, 1);
      chk("R8 first frame kept", rx_ctrl[3:0], 4'h6);
      b0 = rx_bundle();
      sclk_pulse(3); cyc(20);
      chk("R8 flag sticky", ovr_flag, 1);
      chk("R10 next frame", pulses - p0, 2);
      chk("R10 same value", rx_bundle(), b0);
    end

    // R9 reset clears flag and outputs
    rst = 1; cyc(2); rst = 0; cyc(1);
    chk("R9 ovr cleared", ovr_flag, 0);
    chk("R9 outputs cleared", rx_bundle(), 0);

    chk("R7 pulse width", pw_bad, 0);
    chk("R7/R6 data mirror", mirror_bad, 0);
    chk("R4 idle low", idle_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule